// File: doc/BRIEF.md
# Multi-Mode Sweep Timer

A 16-bit timer/counter that advances once per clock cycle in which the selected tick strobe is high. Two tick strobes enter the block, a slow auxiliary one and a fast subsystem one, and a select pin picks between them. The block has four run modes: stop, up, continuous and up/down. Up mode and up/down mode both take their limit from a single period register. In up/down mode the count follows a triangle between zero and the period value.

The block keeps three sticky flags. The limit flag and the zero flag mark the count reaching its limit and the count returning to zero on the way down. An enable pin gates both of them. The capture flag marks a capture event. A capture input is synchronised, and on its rising edge the live count is latched into a capture register. A synchronous clear input returns the count to zero and leaves the mode untouched. Each flag has its own clear bit.

All pins are plain control and status signals. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `sweep_timer`

## Requirements
- R1: After reset the count, the capture register and all three flags are zero. The period register resets to 0xFFFF.
- R2: In stop mode (mode_i = 0) the count holds its value whatever the tick inputs do.
- R3: In up mode (mode_i = 1) each tick moves the count from the period value to zero and from any other value to value + 1. When irq_en_i is high, lim_flag_o is set on the same clock edge at which the count takes the period value.
- R4: In continuous mode (mode_i = 2) each tick adds one, and 0xFFFF wraps to zero. When irq_en_i is high, lim_flag_o is set on the edge at which the count becomes 0xFFFF.
- R5: In up/down mode (mode_i = 3) the count rises by one per tick up to the period value and then falls by one per tick to zero, repeatedly. With period P > 0 the sequence is 0, 1, …, P, P-1, …, 0, 1, …
- R6: In up/down mode with irq_en_i high, lim_flag_o is set when the count reaches P while rising. zero_flag_o is set on the edge at which the count becomes zero while falling.
- R7: src_sel_i = 0 selects slow_tick_i and src_sel_i = 1 selects fast_tick_i. The unselected strobe has no effect on the count.
- R8: While irq_en_i is low, neither lim_flag_o nor zero_flag_o becomes set.
- R9: flag_clr_i bit 0 clears lim_flag_o, bit 1 clears zero_flag_o and bit 2 clears cap_flag_o. Each bit leaves the other flags unchanged.
- R10: Suppose that in up mode the period is rewritten to a value below the current count. The count then keeps rising through 0xFFFF, wraps to zero, and from there on turns at the new period value.
- R11: A high clr_i sets the count to zero on the next edge, ahead of any tick. It does not change the mode, so counting resumes afterwards.
- R12: A rising edge on cap_in_i is seen through a two-stage synchroniser. On the third clock edge after the input first goes high, the count is copied to cap_val_o and cap_flag_o is set. A level held high and a falling edge latch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Run mode: 0 stop, 1 up, 2 continuous, 3 up/down |
| src_sel_i | input | 1 | Tick source select: 0 slow, 1 fast |
| slow_tick_i | input | 1 | Slow auxiliary tick strobe |
| fast_tick_i | input | 1 | Fast subsystem tick strobe |
| clr_i | input | 1 | Synchronous count clear |
| per_wr_i | input | 1 | Period register write strobe |
| per_data_i | input | 16 | Period value to write |
| irq_en_i | input | 1 | Enables setting of the limit and zero flags |
| cap_in_i | input | 1 | Capture input (asynchronous) |
| flag_clr_i | input | 3 | Per-flag clear: bit 0 limit, bit 1 zero, bit 2 capture |
| count_o | output | 16 | Live count |
| cap_val_o | output | 16 | Count latched at the last capture |
| lim_flag_o | output | 1 | Sticky limit-reached flag |
| zero_flag_o | output | 1 | Sticky return-to-zero flag (up/down mode) |
| cap_flag_o | output | 1 | Sticky capture flag |

## Verification
The hardest case to reach is the period rewrite in up mode. The count must already be above the new period, and the test then has to follow it through the 0xFFFF wrap. The stimulus first counts under a period of 0xFFFF and writes a small period once the count is past it. It then holds the fast tick high for the roughly 65,500 cycles it takes to reach the wrap, and checks that the count goes through 0xFFFF and then turns at the new value. Capture is made deterministic by stopping the counter before cap_in_i rises, so that the latched value is known exactly.

// File: rtl/sweep_timer_pkg.sv
package sweep_timer_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } run_mode_e;

  localparam int FLG_LIM  = 0;
  localparam int FLG_ZERO = 1;
  localparam int FLG_CAP  = 2;
  localparam int N_FLAGS  = 3;
endpackage

// File: rtl/sweep_tick_sel.sv
module sweep_tick_sel #(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] ticks_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) tick_o = ticks_i[i];
    end
  end
endmodule

// File: rtl/sweep_count_core.sv
module sweep_count_core
  import sweep_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  run_mode_e        mode_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_lim_o,
  output logic             hit_zero_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             up_q, up_d, falling, advance;

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    falling = 1'b0;
    unique case (mode_i)
      MODE_STOP: ;
      MODE_UP:   cnt_d = (cnt_q == period_i) ? '0 : cnt_q + 1'b1;
      MODE_CONT: cnt_d = cnt_q + 1'b1;
      MODE_UPDN: begin
        if (up_q) begin
          if (cnt_q >= period_i) begin
            falling = 1'b1;
            up_d    = 1'b0;
            cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            up_d  = 1'b1;
            cnt_d = (period_i == '0) ? '0 : CNT_W'(1);
          end else begin
            falling = 1'b1;
            cnt_d   = cnt_q - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign limit      = (mode_i == MODE_CONT) ? ALL_ONES : period_i;
  assign advance    = tick_i && (mode_i != MODE_STOP) && !clr_i;
  assign hit_lim_o  = advance && !falling && (cnt_d == limit);
  assign hit_zero_o = advance && (mode_i == MODE_UPDN) && falling && (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      if (advance) cnt_q <= cnt_d;
      if (mode_i != MODE_UPDN) up_q <= 1'b1;
      else if (advance)        up_q <= up_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sweep_capture.sv
module sweep_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= cap_in_i;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign cap_evt_o = sync_q[SYNC_STAGES-1] && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      cap_val_o <= '0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (cap_evt_o) cap_val_o <= count_i;
    end
  end
endmodule

// File: rtl/sweep_flag_bank.sv
module sweep_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar f = 0; f < N; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[f] <= 1'b0;
      else if (set_i[f]) flags_o[f] <= 1'b1;
      else if (clr_i[f]) flags_o[f] <= 1'b0;
    end
  end
endmodule

// File: rtl/sweep_timer.sv
module sweep_timer
  import sweep_timer_pkg::*;
#(
  parameter int               CNT_W        = 16,
  parameter int               SYNC_STAGES  = 2,
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             src_sel_i,
  input  logic             slow_tick_i,
  input  logic             fast_tick_i,
  input  logic             clr_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_data_i,
  input  logic             irq_en_i,
  input  logic             cap_in_i,
  input  logic [2:0]       flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             lim_flag_o,
  output logic             zero_flag_o,
  output logic             cap_flag_o
);
  logic [CNT_W-1:0]   period_q;
  logic               tick, hit_lim, hit_zero, cap_evt;
  logic [N_FLAGS-1:0] flag_set, flags;
  run_mode_e          mode;

  assign mode = run_mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        period_q <= RESET_PERIOD;
    else if (per_wr_i) period_q <= per_data_i;
  end

  sweep_tick_sel #(.N_SRC(2)) u_sel (
    .ticks_i ({fast_tick_i, slow_tick_i}),
    .sel_i   (src_sel_i),
    .tick_o  (tick)
  );

  sweep_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .tick_i     (tick),
    .clr_i      (clr_i),
    .period_i   (period_q),
    .count_o    (count_o),
    .hit_lim_o  (hit_lim),
    .hit_zero_o (hit_zero)
  );

  sweep_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_in_i  (cap_in_i),
    .count_i   (count_o),
    .cap_val_o (cap_val_o),
    .cap_evt_o (cap_evt)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_LIM]  = hit_lim && irq_en_i;
    flag_set[FLG_ZERO] = hit_zero && irq_en_i;
    flag_set[FLG_CAP]  = cap_evt;
  end

  sweep_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr_i),
    .flags_o (flags)
  );

  assign lim_flag_o  = flags[FLG_LIM];
  assign zero_flag_o = flags[FLG_ZERO];
  assign cap_flag_o  = flags[FLG_CAP];
endmodule

// File: rtl/sweep_timer_chk.sv
module sweep_timer_chk
  import sweep_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             src_sel_i,
  input logic             slow_tick_i,
  input logic             fast_tick_i,
  input logic             clr_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             lim_flag_o,
  input logic             zero_flag_o
);
  logic sel_tick;
  assign sel_tick = src_sel_i ? fast_tick_i : slow_tick_i;

  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'(MODE_STOP) && !clr_i) |=> $stable(count_o));

  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));

  a_r4_cont_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'(MODE_CONT) && !clr_i && sel_tick)
      |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r7_no_tick_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_tick && !clr_i) |=> $stable(count_o));

  a_r8_lim_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_i && !lim_flag_o) |=> !lim_flag_o);

  a_r8_zero_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_i && !zero_flag_o) |=> !zero_flag_o);
endmodule

bind sweep_timer sweep_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .src_sel_i   (src_sel_i),
  .slow_tick_i (slow_tick_i),
  .fast_tick_i (fast_tick_i),
  .clr_i       (clr_i),
  .irq_en_i    (irq_en_i),
  .count_o     (count_o),
  .lim_flag_o  (lim_flag_o),
  .zero_flag_o (zero_flag_o)
);

// File: tb/sweep_timer_tb.sv
module sweep_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        src_sel_i = 1'b1;
  logic        slow_tick_i = 1'b0;
  logic        fast_tick_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        per_wr_i = 1'b0;
  logic [15:0] per_data_i = '0;
  logic        irq_en_i = 1'b0;
  logic        cap_in_i = 1'b0;
  logic [2:0]  flag_clr_i = '0;
  logic [15:0] count_o, cap_val_o;
  logic        lim_flag_o, zero_flag_o, cap_flag_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sweep_timer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .src_sel_i(src_sel_i),
    .slow_tick_i(slow_tick_i), .fast_tick_i(fast_tick_i), .clr_i(clr_i),
    .per_wr_i(per_wr_i), .per_data_i(per_data_i), .irq_en_i(irq_en_i),
    .cap_in_i(cap_in_i), .flag_clr_i(flag_clr_i), .count_o(count_o),
    .cap_val_o(cap_val_o), .lim_flag_o(lim_flag_o), .zero_flag_o(zero_flag_o),
    .cap_flag_o(cap_flag_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick_n(input int n);
    fast_tick_i = 1'b1;
    wait_n(n);
    fast_tick_i = 1'b0;
  endtask

  task automatic do_clear();
    clr_i = 1'b1; wait_n(1); clr_i = 1'b0;
  endtask

  task automatic set_period(input logic [15:0] p);
    per_data_i = p; per_wr_i = 1'b1; wait_n(1); per_wr_i = 1'b0;
  endtask

  task automatic clr_flags(input logic [2:0] m);
    flag_clr_i = m; wait_n(1); flag_clr_i = '0;
  endtask

  task automatic t_reset();
    chk(count_o, 0, "R1 count");
    chk(cap_val_o, 0, "R1 cap_val");
    chk({lim_flag_o, zero_flag_o, cap_flag_o}, 0, "R1 flags");
  endtask

  task automatic t_cont_stop_src();
    mode_i = 2'd2; tick_n(7);
    chk(count_o, 7, "R4 continuous step");
    mode_i = 2'd0; tick_n(5);
    chk(count_o, 7, "R2 stop holds");
    mode_i = 2'd2; src_sel_i = 1'b0; tick_n(4);
    chk(count_o, 7, "R7 unselected fast ignored");
    slow_tick_i = 1'b1; wait_n(3); slow_tick_i = 1'b0;
    chk(count_o, 10, "R7 slow selected");
    src_sel_i = 1'b1;
    do_clear();
    chk(count_o, 0, "R11 clear zero");
    tick_n(2);
    chk(count_o, 2, "R11 mode kept");
  endtask

  task automatic t_capture();
    do_clear(); mode_i = 2'd2; tick_n(9); mode_i = 2'd0;
    cap_in_i = 1'b1; wait_n(2);
    chk(cap_flag_o, 0, "R12 not before third edge");
    wait_n(1);
    chk(cap_val_o, 9, "R12 latched value");
    chk(cap_flag_o, 1, "R12 flag set");
    clr_flags(3'b100);
    chk(cap_flag_o, 0, "R9 cap flag clear");
    mode_i = 2'd2; tick_n(3); mode_i = 2'd0; wait_n(4);
    chk(cap_val_o, 9, "R12 level no recapture");
    chk(cap_flag_o, 0, "R12 level no flag");
    cap_in_i = 1'b0; wait_n(4);
    chk(cap_val_o, 9, "R12 falling ignored");
    chk(cap_flag_o, 0, "R12 falling no flag");
  endtask

  task automatic t_up();
    logic [15:0] e;
    do_clear(); set_period(16'd4); irq_en_i = 1'b1; clr_flags(3'b111);
    mode_i = 2'd1; e = 0;
    for (int i = 0; i < 6; i++) begin
      tick_n(1);
      e = (e == 16'd4) ? 16'd0 : e + 16'd1;
      chk(count_o, e, "R3 up sequence");
      if (i == 2) chk(lim_flag_o, 0, "R3 flag not early");
      if (i == 3) chk(lim_flag_o, 1, "R3 flag at period");
    end
  endtask

  task automatic t_updown();
    int seq [7] = '{1, 2, 3, 2, 1, 0, 1};
    mode_i = 2'd0; do_clear(); set_period(16'd3); irq_en_i = 1'b1; clr_flags(3'b111);
    mode_i = 2'd3;
    for (int i = 0; i < 7; i++) begin
      tick_n(1);
      chk(count_o, seq[i], "R5 triangle");
      if (i == 2) chk({lim_flag_o, zero_flag_o}, 2'b10, "R6 limit at top");
      if (i == 4) chk(zero_flag_o, 0, "R6 zero not early");
      if (i == 5) chk(zero_flag_o, 1, "R6 zero on descent");
    end
    clr_flags(3'b010);
    chk({lim_flag_o, zero_flag_o}, 2'b10, "R9 zero cleared only");
    clr_flags(3'b001);
    chk(lim_flag_o, 0, "R9 limit cleared");
  endtask

  task automatic t_irq_off();
    mode_i = 2'd0; do_clear(); set_period(16'd2); irq_en_i = 1'b0;
    mode_i = 2'd1; tick_n(3);
    chk(count_o, 0, "R8 wrapped");
    chk(lim_flag_o, 0, "R8 limit gated");
    mode_i = 2'd3; tick_n(4);
    chk(zero_flag_o, 0, "R8 zero gated");
  endtask

  task automatic t_period_rewrite();
    mode_i = 2'd0; do_clear(); set_period(16'hFFFF); irq_en_i = 1'b1; clr_flags(3'b111);
    mode_i = 2'd1; tick_n(16);
    chk(count_o, 16'h10, "R10 pre-write count");
    set_period(16'd5);
    tick_n(1);
    chk(count_o, 16'h11, "R10 no early wrap");
    tick_n(16'hFFFF - 16'h11);
    chk(count_o, 16'hFFFF, "R10 reaches top");
    chk(lim_flag_o, 0, "R10 no flag at top");
    tick_n(1);
    chk(count_o, 0, "R10 wraps to zero");
    tick_n(5);
    chk(count_o, 5, "R10 new period");
    chk(lim_flag_o, 1, "R10 flag at new period");
    tick_n(1);
    chk(count_o, 0, "R10 turns at new period");
  endtask

  task automatic t_cont_full();
    mode_i = 2'd0; do_clear(); irq_en_i = 1'b1; clr_flags(3'b111);
    mode_i = 2'd2; tick_n(65534);
    chk(lim_flag_o, 0, "R4 flag not early");
    tick_n(1);
    chk(count_o, 16'hFFFF, "R4 reaches max");
    chk(lim_flag_o, 1, "R4 flag at max");
    tick_n(1);
    chk(count_o, 0, "R4 wraps");
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_cont_stop_src();
    t_capture();
    t_up();
    t_updown();
    t_irq_off();
    t_period_rewrite();
    t_cont_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule